// File: doc/BRIEF.md
# Up-Counting Alarm Timer with Self-Advancing Compare

The block keeps a 64-bit count that rises by one on every clock and never restarts on its own. A 64-bit compare value is held against it. While the comparator is enabled and armed, any cycle in which the count is at or above the compare value is a hit. A hit sets a sticky flag, and that flag drives the interrupt line.

Two modes decide what follows a hit. In single-shot mode the comparator disarms itself, so no further hits occur until software writes the compare value or turns the enable back on. In periodic mode a programmed step is added to the compare value on the same clock edge that records the hit. The sum wraps modulo 2^64, and detection carries on against the new value. The count is never disturbed, so periods follow each other without gaps.

Software reaches the count, compare value, step, control and status through a simple write port and a read port, one 32-bit half per address.

Top module: `upcount_alarm`

## Requirements
- R1: The count rises by exactly 1 every clock, wrapping modulo 2^64. A write to address 0 (low half) or address 1 (high half) loads that half from the write data on that edge, keeps the other half, and suppresses the increment for that edge.
- R2: A hit is a cycle with the comparator enabled, armed, and the count >= the compare value (addresses 2 low, 3 high). A hit sets the status flag on the next edge, and `irq` equals that flag.
- R3: In single-shot mode (control bit 1 = 0), a hit disarms the comparator, and the flag is not set again while it stays disarmed, even though the count remains above the compare value.
- R4: In periodic mode (control bit 1 = 1), a hit replaces the compare value with compare + step (addresses 4 low, 5 high) modulo 2^64 on the same edge. Without a hit and without a write, the compare value holds.
- R5: Writing either half of the compare value re-arms the comparator. A control write that sets bit 0 while the comparator is disabled also re-arms it.
- R6: The flag stays set until a write to address 7 with bit 0 = 1 clears it. A hit on the same edge as the clear leaves the flag set.
- R7: With control bit 0 = 0 (comparator disabled), no hit occurs, whatever the count and compare values are.
- R8: After reset, the count, compare value, step, control, flag and read data are all zero.
- R9: When `rd_en` is high, `rd_data` takes the addressed register on the next edge, sampling the register's value from before that edge. Address 6 returns {periodic, enable} in bits 1:0, and address 7 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that only one register is written per cycle, and that the address and data are stable while `wr_en` is high. The bench drives every write for exactly one clock from the falling edge, so this assumption always holds.

The counter-step and compare-hold properties exclude cycles that write the count or compare registers. The bench therefore sets up the compare value and step with the comparator disabled, and enables it before loading the count, so no partly written 64-bit value can produce an unintended hit. Each wrap case starts from chosen values, so that the catch-up hits after the compare value wraps can be predicted exactly.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int HALVES = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STEP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STEP_HI = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STAT    = 3'd7;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PER_BIT = 1;
endpackage

// File: rtl/alarm_counter.sv
module alarm_counter
  import alarm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [HALVES-1:0]        ld,
  input  logic [BUS_W-1:0]         wdata,
  output logic [HALVES*BUS_W-1:0]  cnt
);
  localparam int CNT_W = HALVES * BUS_W;

  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] nxt;
  logic             any_ld;

  assign inc    = cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  assign any_ld = |ld;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign nxt[h*BUS_W +: BUS_W] = ld[h] ? wdata :
                                   (any_ld ? cnt[h*BUS_W +: BUS_W] : inc[h*BUS_W +: BUS_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
  import alarm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [HALVES*BUS_W-1:0]  cnt,
  input  logic [HALVES-1:0]        ld_cmp,
  input  logic [HALVES-1:0]        ld_step,
  input  logic [BUS_W-1:0]         wdata,
  input  logic                     enable,
  input  logic                     periodic,
  input  logic                     arm_req,
  output logic                     hit,
  output logic                     armed,
  output logic [HALVES*BUS_W-1:0]  cmp,
  output logic [HALVES*BUS_W-1:0]  step
);
  localparam int CNT_W = HALVES * BUS_W;

  logic [CNT_W-1:0] advanced;
  logic [CNT_W-1:0] cmp_nxt;
  logic [CNT_W-1:0] step_nxt;
  logic             cmp_wr;

  assign hit      = enable && armed && (cnt >= cmp);
  assign advanced = cmp + step;
  assign cmp_wr   = |ld_cmp;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign cmp_nxt[h*BUS_W +: BUS_W] =
      ld_cmp[h] ? wdata :
      (cmp_wr ? cmp[h*BUS_W +: BUS_W] :
       ((hit && periodic) ? advanced[h*BUS_W +: BUS_W] : cmp[h*BUS_W +: BUS_W]));
    assign step_nxt[h*BUS_W +: BUS_W] = ld_step[h] ? wdata : step[h*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp   <= '0;
      step  <= '0;
      armed <= 1'b1;
    end else begin
      cmp  <= cmp_nxt;
      step <= step_nxt;
      if (cmp_wr || arm_req)    armed <= 1'b1;
      else if (hit && !periodic) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [1:0]               ctrl_wdata,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [HALVES*BUS_W-1:0]  cnt,
  input  logic [HALVES*BUS_W-1:0]  cmp,
  input  logic [HALVES*BUS_W-1:0]  step,
  input  logic                     hit,
  output logic [HALVES-1:0]        ld_cnt,
  output logic [HALVES-1:0]        ld_cmp,
  output logic [HALVES-1:0]        ld_step,
  output logic                     enable,
  output logic                     periodic,
  output logic                     arm_req,
  output logic                     flag,
  output logic [BUS_W-1:0]         rd_data
);
  logic ctrl_wr;
  logic clr;

  assign ld_cnt  = {wr_en && wr_addr == ADDR_CNT_HI,  wr_en && wr_addr == ADDR_CNT_LO};
  assign ld_cmp  = {wr_en && wr_addr == ADDR_CMP_HI,  wr_en && wr_addr == ADDR_CMP_LO};
  assign ld_step = {wr_en && wr_addr == ADDR_STEP_HI, wr_en && wr_addr == ADDR_STEP_LO};
  assign ctrl_wr = wr_en && wr_addr == ADDR_CTRL;
  assign clr     = wr_en && wr_addr == ADDR_STAT && ctrl_wdata[0];
  assign arm_req = ctrl_wr && ctrl_wdata[CTRL_EN_BIT] && !enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      periodic <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        enable   <= ctrl_wdata[CTRL_EN_BIT];
        periodic <= ctrl_wdata[CTRL_PER_BIT];
      end
      flag <= hit | (flag & ~clr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADDR_CNT_LO:  rd_data <= cnt[BUS_W-1:0];
        ADDR_CNT_HI:  rd_data <= cnt[2*BUS_W-1:BUS_W];
        ADDR_CMP_LO:  rd_data <= cmp[BUS_W-1:0];
        ADDR_CMP_HI:  rd_data <= cmp[2*BUS_W-1:BUS_W];
        ADDR_STEP_LO: rd_data <= step[BUS_W-1:0];
        ADDR_STEP_HI: rd_data <= step[2*BUS_W-1:BUS_W];
        ADDR_CTRL:    rd_data <= {{(BUS_W-2){1'b0}}, periodic, enable};
        default:      rd_data <= {{(BUS_W-1){1'b0}}, flag};
      endcase
    end
  end
endmodule

// File: rtl/upcount_alarm.sv
module upcount_alarm
  import alarm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq
);
  localparam int CNT_W = HALVES * BUS_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [CNT_W-1:0]  step;
  logic [HALVES-1:0] ld_cnt;
  logic [HALVES-1:0] ld_cmp;
  logic [HALVES-1:0] ld_step;
  logic              enable;
  logic              periodic;
  logic              arm_req;
  logic              hit;
  logic              armed;
  logic              flag;

  alarm_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .ctrl_wdata(wr_data[1:0]), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt(cnt), .cmp(cmp), .step(step), .hit(hit),
    .ld_cnt(ld_cnt), .ld_cmp(ld_cmp), .ld_step(ld_step),
    .enable(enable), .periodic(periodic), .arm_req(arm_req),
    .flag(flag), .rd_data(rd_data)
  );

  alarm_counter #(.BUS_W(BUS_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld_cnt), .wdata(wr_data), .cnt(cnt)
  );

  alarm_comparator #(.BUS_W(BUS_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .ld_cmp(ld_cmp), .ld_step(ld_step),
    .wdata(wr_data), .enable(enable), .periodic(periodic), .arm_req(arm_req),
    .hit(hit), .armed(armed), .cmp(cmp), .step(step)
  );

  assign irq = flag;
endmodule

// File: rtl/alarm_checker.sv
module alarm_checker
  import alarm_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             wbit0,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] step,
  input logic             enable,
  input logic             periodic,
  input logic             armed,
  input logic             irq
);
  logic seen_hit;
  logic cnt_wr;
  logic cmp_wr;
  logic ctl_wr;
  logic clr_wr;

  assign seen_hit = enable && armed && (cnt >= cmp);
  assign cnt_wr   = wr_en && (wr_addr == ADDR_CNT_LO || wr_addr == ADDR_CNT_HI);
  assign cmp_wr   = wr_en && (wr_addr == ADDR_CMP_LO || wr_addr == ADDR_CMP_HI);
  assign ctl_wr   = wr_en && wr_addr == ADDR_CTRL;
  assign clr_wr   = wr_en && wr_addr == ADDR_STAT && wbit0;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> cnt == $past(cnt) + 1'b1); // R1
  AST_HIT_RAISES: assert property (@(posedge clk) disable iff (rst)
    seen_hit |=> irq); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!irq && !seen_hit) |=> !irq); // R7
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (seen_hit && !periodic && !cmp_wr && !ctl_wr) |=> !armed); // R3
  AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (seen_hit && periodic && !cmp_wr) |=> cmp == $past(cmp) + $past(step)); // R4
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!seen_hit && !cmp_wr) |=> $stable(cmp)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq); // R6
  AST_REARM_ON_CMP: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> armed); // R5
endmodule

bind upcount_alarm alarm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wbit0(wr_data[0]),
  .cnt(cnt), .cmp(cmp), .step(step), .enable(enable), .periodic(periodic),
  .armed(armed), .irq(irq)
);

// File: tb/upcount_alarm_test.sv
`timescale 1ns/1ps
module upcount_alarm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 0;

  upcount_alarm uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_irq(input int limit);
    while (!irq && n < limit) tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R8 irq after reset", irq, 0);
    chk("R8 rd_data after reset", rd_data, 0);
    rd(3'd6, d); chk("R8 control", d, 0);
    rd(3'd7, d); chk("R8 status", d, 0);
    rd(3'd2, d); chk("R8 compare low", d, 0);
    rd(3'd5, d); chk("R8 step high", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1000);
    rd(3'd0, d); chk("R1 loaded count", d, 1000);
    repeat (5) tick();
    rd(3'd0, d); chk("R1 count after 6 edges", d, 1006);
    rd(3'd1, d); chk("R9 count high", d, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    int seen;
    wr(3'd6, 32'd0);
    wr(3'd2, 32'd5000);
    wr(3'd3, 32'd0);
    wr(3'd6, 32'd1);
    rd(3'd6, d); chk("R9 control readback", d, 1);
    wr(3'd0, 32'd4990);
    n = 0;
    wait_irq(100);
    chk("R2 hit latency", n, 11);
    rd(3'd7, d); chk("R9 status readback", d, 1);
    wr(3'd7, 32'd1);
    chk("R6 clear", irq, 0);
    seen = 0;
    repeat (40) begin tick(); if (irq) seen++; end
    chk("R3 single-shot stays quiet", seen, 0);
    wr(3'd2, 32'd4000);
    tick();
    chk("R5 compare write re-arms", irq, 1);
    wr(3'd7, 32'd1);
    wr(3'd6, 32'd0);
    wr(3'd2, 32'd100);
    repeat (5) tick();
    chk("R7 disabled no hit", irq, 0);
    wr(3'd6, 32'd1);
    tick();
    chk("R5 enable re-arms", irq, 1);
    wr(3'd7, 32'd1);
  endtask

  task automatic t_collide();
    wr(3'd6, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd3);
    repeat (2) tick();
    wr(3'd7, 32'd1);
    chk("R6 set wins over clear", irq, 1);
    wr(3'd6, 32'd0);
    wr(3'd7, 32'd1);
    chk("R6 clear while disabled", irq, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(3'd2, 32'd20000);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd1000);
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd3);
    wr(3'd0, 32'd19995);
    n = 0;
    wait_irq(100);
    chk("R4 first periodic hit", n, 6);
    wr(3'd7, 32'd1);
    rd(3'd2, d); chk("R4 compare advanced", d, 21000);
    wait_irq(2000);
    chk("R4 second hit one period later", n, 1006);
    wr(3'd6, 32'd0);
    wr(3'd7, 32'd1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(3'd6, 32'd0);
    wr(3'd2, 32'hFFFF_FFF8);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h10);
    wr(3'd5, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd6, 32'd3);
    wr(3'd0, 32'hFFFF_FFF0);
    n = 0;
    wait_irq(100);
    chk("R2 hit near top", n, 9);
    while (n < 39) tick();
    wr(3'd6, 32'd0);
    rd(3'd2, d); chk("R4 wrapped compare low", d, 32'h78);
    rd(3'd3, d); chk("R4 wrapped compare high", d, 0);
    rd(3'd1, d); chk("R1 count wrapped high", d, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_oneshot();
    t_collide();
    t_periodic();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule